// File: doc/BRIEF.md
# Extended Hamming (SECDED) code-word generator

This block turns a K-bit data word into a protected code word of m + K + 1 bits. A decoder downstream can then repair any one flipped bit and flag any two flipped bits. Check bits sit at the power-of-two positions of the word and data bits fill the other positions. One extra bit makes the parity of the whole word even. A parameter chooses whether that bit sits at the low end of the output or at the high end.

The generator drops into a write path in front of a memory or a link. A latency parameter selects a purely combinational path, a single output register, or an input register plus an output register. Every register shares one clock enable and one asynchronous active-low reset.

Top module: `hamx_encoder`

## Requirements
- R1: The check-bit count m is the smallest m >= 1 with 2^m >= m + DATA_W + 1. `code_out` is m + DATA_W + 1 bits wide, which is 13 bits (m = 4) for DATA_W = 8.
- R2: Number the internal code positions 1..n, with n = m + DATA_W. Data bit 0 goes to position 3. Each higher data bit goes to the next position that is not a power of two, so for DATA_W = 8 the positions are 3, 5, 6, 7, 9, 10, 11 and 12.
- R3: The check bit at position 2^i equals the XOR of all other positions in 1..n whose index has bit i set. Therefore the syndrome of any output word is zero. The syndrome is the XOR of the indices of all set positions.
- R4: The overall parity bit sits at internal position 0 and makes the XOR of all n + 1 bits zero.
- R5: With P0_AT_LSB = 1 the internal word is output as it is. With P0_AT_LSB = 0 the parity bit is output at bit n, and internal bits 1..n appear at output bits 0..n-1.
- R6: Inverting any single bit of an output word gives odd overall parity and a syndrome equal to that bit's internal position. For the parity bit itself that syndrome is 0.
- R7: Inverting any two distinct bits of an output word gives even overall parity and a nonzero syndrome.
- R8: With LATENCY = 0, `code_out` follows `data_in` within the same cycle.
- R9: With LATENCY = 1, `code_out` shows the encoding of the `data_in` sampled at the previous enabled rising edge.
- R10: With LATENCY = 2, `code_out` shows the encoding of the `data_in` that the input register captured one enabled edge earlier, which makes two enabled edges of delay.
- R11: While `rst_n` is low, every register clears to zero at once, without waiting for a clock edge.
- R12: While `clk_en` is low, no register changes, so registered outputs hold whatever `data_in` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for the optional registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Register update enable |
| data_in | input | DATA_W | Data word to protect |
| code_out | output | m+DATA_W+1 | Protected code word |

## Verification
The hardest case to reach from the ports is the two-stage configuration with the enable dropped. After the drop, the input register holds one word and the output register holds the word before it, and both must survive changing inputs. The stimulus pushes two known words through back to back, lowers the enable while the data keeps changing, then raises it again. It checks that the first word out is the one frozen in the input stage and not the new input. All 256 data words are also streamed through every latency variant. Each output word is hit with every single-bit and double-bit flip, so the syndrome and parity behaviour is covered for every position, in both placements of the parity bit.

// File: rtl/hamx_pkg.sv
package hamx_pkg;

    // smallest m >= 1 with 2^m >= m + k + 1
    function automatic int chk_bits(input int k);
        int m;
        m = 1;
        while ((1 << m) < m + k + 1) m++;
        return m;
    endfunction

    // full output width: check bits, data bits, overall parity
    function automatic int word_bits(input int k);
        return chk_bits(k) + k + 1;
    endfunction

    function automatic bit is_pow2(input int x);
        return (x > 0) && ((x & (x - 1)) == 0);
    endfunction

    // data index carried by a non-power-of-two position
    function automatic int data_slot(input int pos);
        return pos - $clog2(pos + 1) - 1;
    endfunction

endpackage

// File: rtl/hamx_stage.sv
module hamx_stage #(
    parameter int W          = 8,
    parameter bit REGISTERED = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (REGISTERED) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)  q <= '0;
                else if (en) q <= d;
            end
        end else begin : g_wire
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/hamx_spread.sv
module hamx_spread #(
    parameter int DATA_W = 8,
    localparam int M     = hamx_pkg::chk_bits(DATA_W),
    localparam int N     = M + DATA_W
) (
    input  logic [DATA_W-1:0] data,
    output logic [N:1]        spread
);
    // data bits to non-power-of-two positions, check slots left at zero
    for (genvar pos = 1; pos <= N; pos++) begin : g_pos
        if (hamx_pkg::is_pow2(pos)) begin : g_chk
            assign spread[pos] = 1'b0;
        end else begin : g_dat
            assign spread[pos] = data[hamx_pkg::data_slot(pos)];
        end
    end
endmodule

// File: rtl/hamx_checkgen.sv
module hamx_checkgen #(
    parameter int DATA_W = 8,
    localparam int M     = hamx_pkg::chk_bits(DATA_W),
    localparam int N     = M + DATA_W
) (
    input  logic [N:1] spread,
    output logic [N:0] word
);
    logic [M-1:0] chk;

    always_comb begin
        chk = '0;
        for (int pos = 1; pos <= N; pos++) begin
            for (int i = 0; i < M; i++) begin
                if (pos[i]) chk[i] = chk[i] ^ spread[pos];
            end
        end
    end

    always_comb begin
        word = {spread, 1'b0};
        for (int i = 0; i < M; i++) begin
            word[1 << i] = chk[i];
        end
        word[0] = ^word[N:1];
    end
endmodule

// File: rtl/hamx_orient.sv
module hamx_orient #(
    parameter int W         = 13,
    parameter bit P0_AT_LSB = 1'b1
) (
    input  logic [W-1:0] inner,
    output logic [W-1:0] outer
);
    generate
        if (P0_AT_LSB) begin : g_lsb
            assign outer = inner;
        end else begin : g_msb
            assign outer = {inner[0], inner[W-1:1]};
        end
    endgenerate
endmodule

// File: rtl/hamx_encoder.sv
module hamx_encoder #(
    parameter int DATA_W    = 8,
    parameter int LATENCY   = 2,
    parameter bit P0_AT_LSB = 1'b1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  clk_en,
    input  logic [DATA_W-1:0]                     data_in,
    output logic [hamx_pkg::word_bits(DATA_W)-1:0] code_out
);
    localparam int M   = hamx_pkg::chk_bits(DATA_W);
    localparam int N   = M + DATA_W;
    localparam bit IN_REG  = (LATENCY >= 2);
    localparam bit OUT_REG = (LATENCY >= 1);

    logic [DATA_W-1:0] data_q;
    logic [N:1]        spread_w;
    logic [N:0]        inner_w;
    logic [N:0]        oriented_w;

    hamx_stage #(.W(DATA_W), .REGISTERED(IN_REG)) u_in_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (clk_en),
        .d     (data_in),
        .q     (data_q)
    );

    hamx_spread #(.DATA_W(DATA_W)) u_spread (
        .data   (data_q),
        .spread (spread_w)
    );

    hamx_checkgen #(.DATA_W(DATA_W)) u_checkgen (
        .spread (spread_w),
        .word   (inner_w)
    );

    hamx_orient #(.W(N + 1), .P0_AT_LSB(P0_AT_LSB)) u_orient (
        .inner (inner_w),
        .outer (oriented_w)
    );

    hamx_stage #(.W(N + 1), .REGISTERED(OUT_REG)) u_out_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (clk_en),
        .d     (oriented_w),
        .q     (code_out)
    );
endmodule

// File: rtl/hamx_encoder_chk.sv
module hamx_encoder_chk #(
    parameter int DATA_W    = 8,
    parameter int LATENCY   = 2,
    parameter bit P0_AT_LSB = 1'b1
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic                                  clk_en,
    input logic [DATA_W-1:0]                     data_in,
    input logic [hamx_pkg::word_bits(DATA_W)-1:0] code_out
);
    localparam int M = hamx_pkg::chk_bits(DATA_W);
    localparam int N = M + DATA_W;

    logic [N:0]        inner;
    logic [M-1:0]      syn;
    logic [DATA_W-1:0] field;

    always_comb begin
        if (P0_AT_LSB) inner = code_out;
        else           inner = {code_out[N-1:0], code_out[N]};
    end

    always_comb begin
        int slot;
        syn   = '0;
        field = '0;
        slot  = 0;
        for (int pos = 1; pos <= N; pos++) begin
            if (inner[pos]) syn = syn ^ M'(pos);
            if (!hamx_pkg::is_pow2(pos)) begin
                field[slot] = inner[pos];
                slot++;
            end
        end
    end

    // R4
    parity_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (^code_out) == 1'b0);

    // R3
    syndrome_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        syn == '0);

    generate
        if (LATENCY == 0) begin : g_comb
            // R8
            comb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                field == data_in);
        end else begin : g_regd
            // R11
            reset_clear_chk: assert property (@(posedge clk)
                !rst_n |-> code_out == '0);
            // R12
            enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !clk_en |=> $stable(code_out));
            if (LATENCY == 1) begin : g_one
                // R9
                one_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    clk_en |=> field == $past(data_in));
            end
        end
    endgenerate
endmodule

bind hamx_encoder hamx_encoder_chk #(
    .DATA_W    (DATA_W),
    .LATENCY   (LATENCY),
    .P0_AT_LSB (P0_AT_LSB)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .data_in  (data_in),
    .code_out (code_out)
);

// File: tb/sim_hamx_encoder.sv
`timescale 1ns/1ps
module sim_hamx_encoder;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        clk_en;
    logic [7:0]  data;
    logic [12:0] code0, code1, code2;
    int checks = 0;
    int errors = 0;
    logic [7:0] hist [0:259];

    always #2 clk = ~clk;

    hamx_encoder #(.DATA_W(8), .LATENCY(2), .P0_AT_LSB(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .data_in(data), .code_out(code0));
    hamx_encoder #(.DATA_W(8), .LATENCY(1), .P0_AT_LSB(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .data_in(data), .code_out(code1));
    hamx_encoder #(.DATA_W(8), .LATENCY(0), .P0_AT_LSB(1'b1)) u2 (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .data_in(data), .code_out(code2));

    function automatic logic [12:0] ref_enc(input logic [7:0] d, input bit lsb);
        logic [12:0] w;
        logic [3:0]  s;
        int slot;
        w = '0; s = '0; slot = 0;
        for (int pos = 1; pos <= 12; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                w[pos] = d[slot];
                if (d[slot]) s = s ^ 4'(pos);
                slot++;
            end
        end
        for (int b = 0; b < 4; b++) w[1 << b] = s[b];
        w[0] = ^w[12:1];
        return lsb ? w : {w[0], w[12:1]};
    endfunction

    function automatic logic [3:0] ref_syn(input logic [12:0] w);
        logic [3:0] s;
        s = '0;
        for (int pos = 1; pos <= 12; pos++) if (w[pos]) s = s ^ 4'(pos);
        return s;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [12:0] act, input logic [12:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R6 and R7 on an internal-order word
    task automatic flip_test(input logic [12:0] w);
        bit ok1, ok2;
        logic [12:0] f;
        ok1 = 1'b1; ok2 = 1'b1;
        for (int j = 0; j <= 12; j++) begin
            f = w ^ (13'd1 << j);
            if (!((^f) == 1'b1 && ref_syn(f) == 4'(j))) ok1 = 1'b0;
            for (int k = j + 1; k <= 12; k++) begin
                f = w ^ (13'd1 << j) ^ (13'd1 << k);
                if (!((^f) == 1'b0 && ref_syn(f) != 4'd0)) ok2 = 1'b0;
            end
        end
        chk(ok1, "R6 single flip", w, w);
        chk(ok2, "R7 double flip", w, w);
    endtask

    task automatic finish_up;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_up();
    end

    initial begin
        logic [12:0] o0, o1;
        int wpos [0:7];
        wpos = '{3, 5, 6, 7, 9, 10, 11, 12};
        rst_n = 1'b0; clk_en = 1'b1; data = 8'h00;
        #1;
        // R11 async clear at time zero
        chk(code0 == 13'd0, "R11 reset u0", code0, 13'd0);
        chk(code1 == 13'd0, "R11 reset u1", code1, 13'd0);
        // R1 width
        chk($bits(code0) == 13, "R1 width", 13'($bits(code0)), 13'd13);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R2 placement of single data bits
        for (int j = 0; j < 8; j++) begin
            data = 8'd1 << j;
            #1;
            chk(code2[wpos[j]] == 1'b1, "R2 data position", code2, ref_enc(data, 1'b1));
            @(negedge clk);
        end

        // stream all words: R8 R9 R10 R5 R3 R4 R6 R7
        for (int t = 0; t < 258; t++) begin
            @(negedge clk);
            if (t >= 1) begin
                chk(code1 == ref_enc(hist[t-1], 1'b0), "R9 one stage, R5 msb", code1, ref_enc(hist[t-1], 1'b0));
                if (t - 1 < 256) flip_test({code1[11:0], code1[12]});
            end
            if (t >= 2)
                chk(code0 == ref_enc(hist[t-2], 1'b1), "R10 two stages", code0, ref_enc(hist[t-2], 1'b1));
            hist[t] = t[7:0];
            data = hist[t];
            #1;
            chk(code2 == ref_enc(hist[t], 1'b1), "R8 comb, R3 R4", code2, ref_enc(hist[t], 1'b1));
            if (t < 256) flip_test(code2);
        end

        // R12 enable hold
        @(negedge clk); data = 8'h5A; clk_en = 1'b1;
        @(negedge clk); data = 8'h77;
        @(negedge clk); clk_en = 1'b0; data = 8'hA5;
        o0 = code0; o1 = code1;
        chk(o0 == ref_enc(8'h5A, 1'b1), "R10 before hold", o0, ref_enc(8'h5A, 1'b1));
        chk(o1 == ref_enc(8'h77, 1'b0), "R9 before hold", o1, ref_enc(8'h77, 1'b0));
        for (int r = 0; r < 3; r++) begin
            @(negedge clk);
            chk(code0 == o0, "R12 hold u0", code0, o0);
            chk(code1 == o1, "R12 hold u1", code1, o1);
            data = data + 8'd13;
        end
        @(negedge clk); clk_en = 1'b1; data = 8'h3C;
        @(negedge clk);
        chk(code1 == ref_enc(8'h3C, 1'b0), "R12 resume u1", code1, ref_enc(8'h3C, 1'b0));
        chk(code0 == ref_enc(8'h77, 1'b1), "R12 input stage held", code0, ref_enc(8'h77, 1'b1));

        // R11 async clear mid-run
        #1 rst_n = 1'b0;
        #0.5;
        chk(code0 == 13'd0, "R11 async u0", code0, 13'd0);
        chk(code1 == 13'd0, "R11 async u1", code1, 13'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        finish_up();
    end
endmodule